// File: doc/BRIEF.md
# Bit, Shift and Rotate Unit

A purely combinational datapath slice that handles the byte-level bit-manipulation group of an 8-bit processor core. It takes one operand byte, a three-bit bit index, the current flag nibble and an operation code. It returns the new byte, the new flag nibble and a write-enable that tells the register-file or memory write-back stage whether the byte must be stored.

The unit covers the circular and through-carry rotates in both directions, one left shift and two right shifts, the nibble exchange, and the single-bit test, clear and set. An accumulator short-form select changes only the flag rule of the four rotates: the zero flag is then held low and not computed. Opcode decoding and memory read-modify-write sequencing are left to the surrounding core.

Top module: `bsr_unit`

## Requirements
- R1: Circular rotates: code 0 (left) gives {d[6:0],d[7]} with C=d[7]; code 1 (right) gives {d[0],d[7:1]} with C=d[0].
- R2: Through-carry rotates: code 2 (left) gives {d[6:0],Cin} with C=d[7]; code 3 (right) gives {Cin,d[7:1]} with C=d[0].
- R3: Shifts: code 4 gives {d[6:0],0} with C=d[7]; code 5 gives {d[7],d[7:1]} with C=d[0]; code 7 gives {0,d[7:1]} with C=d[0].
- R4: With short form low, codes 0 to 5 and 7 set Z when the result byte is zero and clear N and H. The flag nibble is {Z,N,H,C} from bit 3 down to bit 0.
- R5: With short form high, codes 0 to 3 force Z, N and H to 0, keep the long-form result byte, and set C from the bit shifted out. Short form has no effect on any other code.
- R6: Code 6 exchanges the two nibbles, sets Z from the result and clears N, H and C.
- R7: Code 8 (bit test) sets Z when operand bit [index] is 0, clears N, sets H, keeps C, returns the operand unchanged and holds the write-enable low.
- R8: Code 9 clears and code 10 sets operand bit [index], with all other bits and all four flags unchanged.
- R9: Codes 11 to 15 return the operand and the incoming flags unchanged, with the write-enable low.
- R10: The write-enable is high for codes 0 to 7, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 8 | Operand byte |
| bit_sel_i | input | 3 | Bit index for test, clear and set |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| op_i | input | 4 | Operation code |
| acc_form_i | input | 1 | Accumulator short-form select |
| result_o | output | 8 | Result byte |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| wr_en_o | output | 1 | Result write-enable |

## Verification
The checks assume that every input is a known 0 or 1 value and that the output is sampled only after the inputs have settled. They treat any code above 10 as a defined pass-through case and not as illegal. The stimulus drives all inputs together away from the sampling point. It mixes random codes over the full 4-bit range, random operand, index and flag values, and the short-form select in both states, so that the reserved codes and the short form on non-rotate codes are both exercised.

// File: rtl/bsr_pkg.sv
// Package: shared operation codes and flag layout for the bit, shift and
// rotate unit. Assumes a flag nibble ordered {Z,N,H,C} from MSB to LSB.
package bsr_pkg;

    typedef enum logic [3:0] {
        OP_ROTL_CIRC = 4'd0,
        OP_ROTR_CIRC = 4'd1,
        OP_ROTL_CARRY = 4'd2,
        OP_ROTR_CARRY = 4'd3,
        OP_SHL_ARITH = 4'd4,
        OP_SHR_ARITH = 4'd5,
        OP_NIB_SWAP = 4'd6,
        OP_SHR_LOGIC = 4'd7,
        OP_BIT_TEST = 4'd8,
        OP_BIT_CLR = 4'd9,
        OP_BIT_SET = 4'd10
    } bsr_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } bsr_flags_t;

    localparam int FLAG_W = 4;

    // Rotate codes are the only ones whose flags change with the short form
    function automatic logic is_rotate(input logic [3:0] code);
        return code[3:2] == 2'b00;
    endfunction

    // Codes that go through the shifter datapath
    function automatic logic is_shift_path(input logic [3:0] code);
        return code[3] == 1'b0;
    endfunction

endpackage

// File: rtl/bsr_shifter.sv
// Module: bsr_shifter
// Computes the rotate, shift and nibble-swap results and the bit that
// leaves the operand. Assumes W is even so the nibble exchange is defined.
// Codes outside the shift path return the operand with a zero carry out.
module bsr_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_i,
    input  logic [3:0]   op_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    import bsr_pkg::*;

    localparam int HALF = W / 2;

    logic msb;
    logic lsb;

    assign msb = opnd_i[W-1];
    assign lsb = opnd_i[0];

    // Select the shifted byte and the outgoing bit per operation
    always_comb begin
        res_o  = opnd_i;
        cout_o = 1'b0;
        case (op_i)
            OP_ROTL_CIRC: begin
                res_o  = {opnd_i[W-2:0], msb};
                cout_o = msb;
            end
            OP_ROTR_CIRC: begin
                res_o  = {lsb, opnd_i[W-1:1]};
                cout_o = lsb;
            end
            OP_ROTL_CARRY: begin
                res_o  = {opnd_i[W-2:0], cin_i};
                cout_o = msb;
            end
            OP_ROTR_CARRY: begin
                res_o  = {cin_i, opnd_i[W-1:1]};
                cout_o = lsb;
            end
            OP_SHL_ARITH: begin
                res_o  = {opnd_i[W-2:0], 1'b0};
                cout_o = msb;
            end
            OP_SHR_ARITH: begin
                res_o  = {msb, opnd_i[W-1:1]};
                cout_o = lsb;
            end
            OP_NIB_SWAP: begin
                res_o  = {opnd_i[HALF-1:0], opnd_i[W-1:HALF]};
                cout_o = 1'b0;
            end
            OP_SHR_LOGIC: begin
                res_o  = {1'b0, opnd_i[W-1:1]};
                cout_o = lsb;
            end
            default: begin
                res_o  = opnd_i;
                cout_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bsr_bitops.sv
// Module: bsr_bitops
// Decodes the bit index into a one-hot mask, reports the selected bit and
// forms the cleared or set byte. Assumes the index is below W.
module bsr_bitops #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     opnd_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             set_i,
    output logic [W-1:0]     res_o,
    output logic             bit_o
);
    logic [W-1:0] mask;

    // One decoder lane per bit position
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (idx_i == IDX_W'(i));
    end

    // Tested bit value and the modified byte
    always_comb begin
        bit_o = |(opnd_i & mask);
        res_o = set_i ? (opnd_i | mask) : (opnd_i & ~mask);
    end

endmodule

// File: rtl/bsr_flagsel.sv
// Module: bsr_flagsel
// Builds the outgoing flag nibble and the write-enable from the operation
// class. Assumes the shifter result and carry are for the same operation.
module bsr_flagsel #(
    parameter int W = 8
) (
    input  logic [3:0]                  op_i,
    input  logic                        acc_form_i,
    input  logic [W-1:0]                shift_res_i,
    input  logic                        shift_cout_i,
    input  logic                        test_bit_i,
    input  logic [bsr_pkg::FLAG_W-1:0]  flags_i,
    output logic [bsr_pkg::FLAG_W-1:0]  flags_o,
    output logic                        wr_en_o
);
    import bsr_pkg::*;

    bsr_flags_t fin;
    bsr_flags_t fout;
    logic       res_zero;

    assign fin      = bsr_flags_t'(flags_i);
    assign res_zero = (shift_res_i == '0);
    assign flags_o  = fout;

    // Flag rule per operation class
    always_comb begin
        fout    = fin;
        wr_en_o = 1'b0;
        if (is_rotate(op_i)) begin
            fout.z  = acc_form_i ? 1'b0 : res_zero;
            fout.n  = 1'b0;
            fout.h  = 1'b0;
            fout.c  = shift_cout_i;
            wr_en_o = 1'b1;
        end else if (is_shift_path(op_i)) begin
            fout.z  = res_zero;
            fout.n  = 1'b0;
            fout.h  = 1'b0;
            fout.c  = shift_cout_i;
            wr_en_o = 1'b1;
        end else begin
            case (op_i)
                OP_BIT_TEST: begin
                    fout.z  = ~test_bit_i;
                    fout.n  = 1'b0;
                    fout.h  = 1'b1;
                    fout.c  = fin.c;
                    wr_en_o = 1'b0;
                end
                OP_BIT_CLR, OP_BIT_SET: begin
                    fout    = fin;
                    wr_en_o = 1'b1;
                end
                default: begin
                    fout    = fin;
                    wr_en_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bsr_unit.sv
// Module: bsr_unit (top)
// Combinational bit, shift and rotate unit. Joins the shifter, the bit
// operation lane and the flag selector, and picks the result byte.
// Assumes inputs are stable for the consuming stage's sampling point.
module bsr_unit #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     opnd_i,
    input  logic [IDX_W-1:0] bit_sel_i,
    input  logic [3:0]       flags_i,
    input  logic [3:0]       op_i,
    input  logic             acc_form_i,
    output logic [W-1:0]     result_o,
    output logic [3:0]       flags_o,
    output logic             wr_en_o
);
    import bsr_pkg::*;

    logic [W-1:0] shift_res;
    logic         shift_cout;
    logic [W-1:0] bit_res;
    logic         test_bit;

    bsr_shifter #(.W(W)) u_shift (
        .opnd_i (opnd_i),
        .op_i   (op_i),
        .cin_i  (flags_i[0]),
        .res_o  (shift_res),
        .cout_o (shift_cout)
    );

    bsr_bitops #(.W(W)) u_bits (
        .opnd_i (opnd_i),
        .idx_i  (bit_sel_i),
        .set_i  (op_i == OP_BIT_SET),
        .res_o  (bit_res),
        .bit_o  (test_bit)
    );

    bsr_flagsel #(.W(W)) u_flags (
        .op_i         (op_i),
        .acc_form_i   (acc_form_i),
        .shift_res_i  (shift_res),
        .shift_cout_i (shift_cout),
        .test_bit_i   (test_bit),
        .flags_i      (flags_i),
        .flags_o      (flags_o),
        .wr_en_o      (wr_en_o)
    );

    // Result byte source per operation class
    always_comb begin
        if (is_shift_path(op_i))
            result_o = shift_res;
        else if (op_i == OP_BIT_CLR || op_i == OP_BIT_SET)
            result_o = bit_res;
        else
            result_o = opnd_i;
    end

endmodule

// File: rtl/bsr_unit_chk.sv
// Module: bsr_unit_chk
// Checker bound to bsr_unit. The block has no clock, so the checks are
// immediate assertions evaluated whenever the ports change.
module bsr_unit_chk #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input logic [W-1:0]     opnd_i,
    input logic [IDX_W-1:0] bit_sel_i,
    input logic [3:0]       flags_i,
    input logic [3:0]       op_i,
    input logic             acc_form_i,
    input logic [W-1:0]     result_o,
    input logic [3:0]       flags_o,
    input logic             wr_en_o
);
    import bsr_pkg::*;

    // Port-level relations per operation class
    always_comb begin
        if (op_i == OP_BIT_TEST) begin
            // R7
            bit_test_chk: assert (!wr_en_o && result_o == opnd_i &&
                                  flags_o[0] == flags_i[0] && flags_o[1] &&
                                  !flags_o[2] &&
                                  flags_o[3] == !opnd_i[bit_sel_i]);
        end
        if (op_i == OP_BIT_CLR || op_i == OP_BIT_SET) begin
            // R8
            bit_mod_chk: assert (flags_o == flags_i && wr_en_o &&
                                 $countones(result_o ^ opnd_i) <= 1 &&
                                 result_o[bit_sel_i] == (op_i == OP_BIT_SET));
        end
        if (op_i > 4'd10) begin
            // R9
            reserved_chk: assert (!wr_en_o && result_o == opnd_i &&
                                  flags_o == flags_i);
        end
        if (op_i == OP_NIB_SWAP) begin
            // R6
            swap_chk: assert (flags_o[2:0] == 3'b000 && wr_en_o &&
                              $countones(result_o) == $countones(opnd_i) &&
                              flags_o[3] == (opnd_i == '0));
        end
        if (is_rotate(op_i) && acc_form_i) begin
            // R5
            short_form_chk: assert (flags_o[3:1] == 3'b000 && wr_en_o);
        end
        if (op_i < 4'd8 && op_i != OP_NIB_SWAP &&
            !(is_rotate(op_i) && acc_form_i)) begin
            // R4
            long_flags_chk: assert (flags_o[3] == (result_o == '0) &&
                                    flags_o[2:1] == 2'b00);
        end
        if (op_i == OP_ROTL_CIRC) begin
            // R1
            rot_circ_chk: assert (result_o[0] == opnd_i[W-1] &&
                                  flags_o[0] == opnd_i[W-1]);
        end
        if (op_i == OP_SHL_ARITH) begin
            // R3
            shl_chk: assert (!result_o[0] && flags_o[0] == opnd_i[W-1]);
        end
    end

endmodule

bind bsr_unit bsr_unit_chk #(.W(W)) u_chk (
    .opnd_i     (opnd_i),
    .bit_sel_i  (bit_sel_i),
    .flags_i    (flags_i),
    .op_i       (op_i),
    .acc_form_i (acc_form_i),
    .result_o   (result_o),
    .flags_o    (flags_o),
    .wr_en_o    (wr_en_o)
);

// File: tb/bsr_unit_test.sv
module bsr_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd;
    logic [2:0] bsel;
    logic [3:0] flg;
    logic [3:0] op;
    logic       acc;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic       wr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsr_unit uut (
        .opnd_i     (opnd),
        .bit_sel_i  (bsel),
        .flags_i    (flg),
        .op_i       (op),
        .acc_form_i (acc),
        .result_o   (result),
        .flags_o    (flags_out),
        .wr_en_o    (wr_en)
    );

    // Reference model: returns {wr_en, flags[3:0], result[7:0]}
    function automatic logic [12:0] model(input logic [3:0] c, input logic a,
                                          input logic [7:0] d, input logic [2:0] k,
                                          input logic [3:0] f);
        logic [7:0] r;
        logic       z, n, h, cy, w;
        r = d; z = f[3]; n = f[2]; h = f[1]; cy = f[0]; w = 1'b0;
        case (c)
            4'd0: begin r = 8'((d << 1) | (d >> 7)); cy = d[7]; end
            4'd1: begin r = 8'((d >> 1) | (d << 7)); cy = d[0]; end
            4'd2: begin r = 8'((d << 1) | 8'(f[0])); cy = d[7]; end
            4'd3: begin r = 8'((d >> 1) | (8'(f[0]) << 7)); cy = d[0]; end
            4'd4: begin r = 8'(d << 1); cy = d[7]; end
            4'd5: begin r = 8'($signed(d) >>> 1); cy = d[0]; end
            4'd6: begin r = 8'((d << 4) | (d >> 4)); cy = 1'b0; end
            4'd7: begin r = 8'(d >> 1); cy = d[0]; end
            4'd8: begin z = ((d >> k) & 8'd1) == 8'd0; n = 0; h = 1; end
            4'd9:  r = d & ~(8'd1 << k);
            4'd10: r = d | (8'd1 << k);
            default: r = d;
        endcase
        if (c <= 4'd7) begin
            n = 0; h = 0; w = 1;
            z = (r == 8'd0);
            if (c <= 4'd3 && a) z = 0;
        end
        if (c == 4'd9 || c == 4'd10) w = 1;
        return {w, z, n, h, cy, r};
    endfunction

    function automatic string req_of(input logic [3:0] c, input logic a);
        case (c)
            4'd0, 4'd1: return a ? "R1/R5" : "R1/R4";
            4'd2, 4'd3: return a ? "R2/R5" : "R2/R4";
            4'd4, 4'd5, 4'd7: return a ? "R3/R4/R5" : "R3/R4";
            4'd6: return "R6";
            4'd8: return "R7";
            4'd9, 4'd10: return "R8/R10";
            default: return "R9";
        endcase
    endfunction

    // Drive at the rising edge, compare at the falling edge
    task automatic apply(input logic [3:0] c, input logic a, input logic [7:0] d,
                         input logic [2:0] k, input logic [3:0] f);
        logic [12:0] exp_v;
        @(posedge clk);
        op = c; acc = a; opnd = d; bsel = k; flg = f;
        @(negedge clk);
        exp_v = model(c, a, d, k, f);
        n_checks++;
        if ({wr_en, flags_out, result} !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d acc=%0b d=%h k=%0d f=%h: got wr=%0b fl=%h res=%h exp wr=%0b fl=%h res=%h",
                     req_of(c, a), c, a, d, k, f, wr_en, flags_out, result,
                     exp_v[12], exp_v[11:8], exp_v[7:0]);
        end
    endtask

    initial begin
        op = 4'd0; acc = 1'b0; opnd = 8'h00; bsel = 3'd0; flg = 4'h0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R4: idle inputs give a zero rotate with Z set
        apply(4'd0, 1'b0, 8'h00, 3'd0, 4'h0);
        // R1 directed
        apply(4'd0, 1'b0, 8'h81, 3'd0, 4'h0);
        apply(4'd1, 1'b0, 8'h01, 3'd0, 4'h0);
        // R2: carry enters
        apply(4'd2, 1'b0, 8'h80, 3'd0, 4'h1);
        apply(4'd3, 1'b0, 8'h01, 3'd0, 4'h0);
        // R5: zero result but Z forced low
        apply(4'd2, 1'b1, 8'h80, 3'd0, 4'hE);
        apply(4'd1, 1'b1, 8'h00, 3'd0, 4'hF);
        // R5: short form ignored on shifts and swap
        apply(4'd4, 1'b1, 8'h80, 3'd0, 4'h0);
        apply(4'd6, 1'b1, 8'h00, 3'd0, 4'hF);
        // R3 directed
        apply(4'd5, 1'b0, 8'h81, 3'd0, 4'h0);
        apply(4'd7, 1'b0, 8'h01, 3'd0, 4'h0);
        // R6
        apply(4'd6, 1'b0, 8'hA5, 3'd0, 4'hF);
        // R7: bit 7 clear, bit 0 set, C kept
        apply(4'd8, 1'b0, 8'h7F, 3'd7, 4'h1);
        apply(4'd8, 1'b0, 8'h01, 3'd0, 4'h0);
        // R8 and R10: clear and set at the extremes
        apply(4'd9, 1'b0, 8'hFF, 3'd7, 4'hA);
        apply(4'd10, 1'b0, 8'h00, 3'd0, 4'h5);
        // R9: reserved codes
        apply(4'd11, 1'b1, 8'h3C, 3'd2, 4'h9);
        apply(4'd15, 1'b0, 8'hC3, 3'd5, 4'h6);
        void'($urandom(32'd1234));
        for (int i = 0; i < N_RANDOM; i++) begin
            apply(4'($urandom), 1'($urandom), 8'($urandom), 3'($urandom), 4'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule